// File: doc/BRIEF.md
# Store-Accumulator Bus Cycle Sequencer

This block is a small bus master that issues the bus cycles of one store instruction on a synchronous bus. The bus has an 8-bit data path and a 16-bit address. The block keeps a program counter (PC) and reads an opcode at that address into an instruction register. When the opcode is 0xB7, it reads two further bytes, high byte first, that form an absolute 16-bit target. It then writes the accumulator value to that target. Any other opcode uses one bus cycle and only moves the PC forward.

Each bus cycle takes place on a clock edge at which the cycle strobe `bus_go` is high. For the whole cycle, the address, the read/write level and the write data come from registered state, so they are stable before the edge. Read data on `din` is captured at the closing edge. When `bus_go` is low, the sequencer waits and nothing changes.

The states are ST_FETCH, ST_ADRH, ST_ADRL and ST_STORE. The transitions are:
- ST_FETCH to ST_ADRH when the fetched byte is 0xB7.
- ST_FETCH to ST_FETCH for any other byte (no-op).
- ST_ADRH to ST_ADRL.
- ST_ADRL to ST_STORE.
- ST_STORE to ST_FETCH.

Every transition takes place only on a strobed edge.

Top module: `stacc_seq`

## Requirements
- R1: A synchronous reset sets the PC to START_PC (default 0xC100) and clears the instruction register. After reset the sequencer is in ST_FETCH, so it shows address START_PC with rw=1.
- R2: In an opcode fetch cycle, addr equals the PC and rw is 1. The byte on din is loaded into the instruction register at the closing edge.
- R3: The PC advances by exactly 1 after every strobed read cycle (opcode or operand byte). It does not change in a write cycle.
- R4: After opcode 0xB7, the next two bus cycles are reads at PC+1 and PC+2, taken from the opcode address.
- R5: The first operand byte becomes bits 15:8 of the target address and the second becomes bits 7:0. For example, 0xC2 then 0x00 gives 0xC200.
- R6: The cycle after the second operand byte is a write cycle. In that cycle addr is the target, rw is 0 and dout is the accumulator input.
- R7: In every read cycle, dout is 0x00.
- R8: Any opcode other than 0xB7 takes a single bus cycle. The next cycle is an opcode fetch at the opcode address plus 1.
- R9: An edge with bus_go low changes nothing: addr, rw, dout, PC and the instruction register all hold.
- R10: A store takes exactly four strobed bus cycles (read, read, read, write). It is followed by an opcode fetch at the opcode address plus 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_go | input | 1 | Cycle strobe: the current bus cycle completes at this edge |
| din | input | 8 | Read data returned by memory |
| acc_in | input | 8 | Accumulator value to be stored |
| addr | output | 16 | Bus address |
| rw | output | 1 | 1 = read cycle, 0 = write cycle |
| dout | output | 8 | Write data (0 during reads) |
| pc_o | output | 16 | Current program counter |
| ir_o | output | 8 | Instruction register |

## Verification
The address, rw and dout of a bus cycle are valid during that same cycle, because no register sits between the state and those pins. The bench samples them 1 ns after the falling edge that precedes the strobed rising edge. A loaded byte, a new PC value or a state change becomes visible one rising edge after the strobe. The bench therefore checks pc_o, ir_o and the next cycle's address at the following falling edge. Stalls with bus_go low are checked at each idle falling edge against the values recorded before the stall.

// File: rtl/stacc_pkg.sv
package stacc_pkg;
    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_ADRH  = 2'd1,
        ST_ADRL  = 2'd2,
        ST_STORE = 2'd3
    } seq_st_t;
endpackage

// File: rtl/stacc_fsm.sv
module stacc_fsm
    import stacc_pkg::*;
#(
    parameter int             DW     = 8,
    parameter logic [DW-1:0]  OPC_ST = 8'hB7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [DW-1:0] din,
    output seq_st_t       state
);
    seq_st_t state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (go) begin
            unique case (state)
                ST_FETCH: state_nx = (din == OPC_ST) ? ST_ADRH : ST_FETCH;
                ST_ADRH:  state_nx = ST_ADRL;
                ST_ADRL:  state_nx = ST_STORE;
                ST_STORE: state_nx = ST_FETCH;
                default:  state_nx = ST_FETCH;
            endcase
        end
    end
endmodule

// File: rtl/stacc_pc.sv
module stacc_pc #(
    parameter int            AW       = 16,
    parameter logic [AW-1:0] START_PC = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    output logic [AW-1:0] pc
);
    always_ff @(posedge clk) begin
        if (rst)      pc <= START_PC;
        else if (inc) pc <= pc + AW'(1);
    end
endmodule

// File: rtl/stacc_opreg.sv
module stacc_opreg #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_ir,
    input  logic            ld_hi,
    input  logic            ld_lo,
    input  logic [DW-1:0]   din,
    output logic [DW-1:0]   ir,
    output logic [2*DW-1:0] ea
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ir <= '0;
            ea <= '0;
        end else begin
            if (ld_ir) ir <= din;
            if (ld_hi) ea[2*DW-1:DW] <= din;
            if (ld_lo) ea[DW-1:0]    <= din;
        end
    end
endmodule

// File: rtl/stacc_seq.sv
module stacc_seq
    import stacc_pkg::*;
#(
    parameter int                DW       = 8,
    localparam int               AW       = 2 * DW,
    parameter logic [2*DW-1:0]   START_PC = 16'hC100,
    parameter logic [DW-1:0]     OPC_ST   = 8'hB7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_go,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] acc_in,
    output logic [AW-1:0] addr,
    output logic          rw,
    output logic [DW-1:0] dout,
    output logic [AW-1:0] pc_o,
    output logic [DW-1:0] ir_o
);
    seq_st_t       state;
    logic [AW-1:0] pc;
    logic [AW-1:0] ea;
    logic          is_rd;

    stacc_fsm #(.DW(DW), .OPC_ST(OPC_ST)) fsm_i (
        .clk   (clk),
        .rst   (rst),
        .go    (bus_go),
        .din   (din),
        .state (state)
    );

    assign is_rd = (state != ST_STORE);

    stacc_pc #(.AW(AW), .START_PC(START_PC)) pc_i (
        .clk (clk),
        .rst (rst),
        .inc (bus_go && is_rd),
        .pc  (pc)
    );

    stacc_opreg #(.DW(DW)) opr_i (
        .clk   (clk),
        .rst   (rst),
        .ld_ir (bus_go && (state == ST_FETCH)),
        .ld_hi (bus_go && (state == ST_ADRH)),
        .ld_lo (bus_go && (state == ST_ADRL)),
        .din   (din),
        .ir    (ir_o),
        .ea    (ea)
    );

    always_comb begin
        addr = pc;
        rw   = 1'b1;
        dout = '0;
        unique case (state)
            ST_FETCH, ST_ADRH, ST_ADRL: begin
                addr = pc;
                rw   = 1'b1;
            end
            ST_STORE: begin
                addr = ea;
                rw   = 1'b0;
                dout = acc_in;
            end
            default: ;
        endcase
    end

    assign pc_o = pc;
endmodule

// File: rtl/stacc_chk.sv
module stacc_chk #(
    parameter int              DW       = 8,
    parameter logic [2*DW-1:0] START_PC = 16'hC100
) (
    input logic            clk,
    input logic            rst,
    input logic            bus_go,
    input logic [2*DW-1:0] addr,
    input logic            rw,
    input logic [DW-1:0]   dout,
    input logic [2*DW-1:0] pc_o,
    input logic [DW-1:0]   ir_o
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_o == START_PC && ir_o == '0 && rw && addr == START_PC));

    assert_read_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_go && rw) |=> (pc_o == $past(pc_o) + 1'b1));

    assert_write_pc_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_go && !rw) |=> $stable(pc_o));

    assert_read_dout_zero_R7: assert property (@(posedge clk) disable iff (rst)
        rw |-> (dout == '0));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_go |=> ($stable(addr) && $stable(rw) && $stable(pc_o) && $stable(ir_o)));

    assert_write_then_fetch_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_go && !rw) |=> (rw && addr == pc_o));
endmodule

bind stacc_seq stacc_chk #(.DW(DW), .START_PC(START_PC)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .bus_go (bus_go),
    .addr   (addr),
    .rw     (rw),
    .dout   (dout),
    .pc_o   (pc_o),
    .ir_o   (ir_o)
);

// File: tb/stacc_seq_tb.sv
module stacc_seq_tb_top;
    localparam logic [15:0] START = 16'hC100;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_go;
    logic [7:0]  din;
    logic [7:0]  acc_in;
    logic [15:0] addr;
    logic        rw;
    logic [7:0]  dout;
    logic [15:0] pc_o;
    logic [7:0]  ir_o;

    int          n_chk = 0;
    int          n_err = 0;
    logic [15:0] exp_pc;
    bit          done = 0;

    always #4 clk = ~clk;

    stacc_seq #(.START_PC(START)) dut_i (
        .clk(clk), .rst(rst), .bus_go(bus_go), .din(din), .acc_in(acc_in),
        .addr(addr), .rw(rw), .dout(dout), .pc_o(pc_o), .ir_o(ir_o)
    );

    task automatic chk(input logic ok, input string rq, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // one strobed bus cycle: check the pins, then let the edge complete it
    task automatic cyc(input logic [7:0] rd, input logic [15:0] ea,
                       input logic erw, input logic [7:0] edo, input string rq);
        @(negedge clk);
        bus_go = 1'b1;
        din    = rd;
        #1;
        chk(addr == ea, rq, "addr", addr, ea);
        chk(rw == erw, rq, "rw", 16'(rw), 16'(erw));
        chk(dout == edo, rq, "dout", 16'(dout), 16'(edo));
    endtask

    task automatic store(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] acc);
        acc_in = acc;
        cyc(8'hB7, exp_pc, 1'b1, 8'h00, "R2");
        cyc(hi, exp_pc + 16'd1, 1'b1, 8'h00, "R4");
        cyc(lo, exp_pc + 16'd2, 1'b1, 8'h00, "R4");
        cyc(8'h00, {hi, lo}, 1'b0, acc, "R6_R5");
        exp_pc = exp_pc + 16'd3;
        @(negedge clk);
        bus_go = 1'b0;
        #1;
        chk(pc_o == exp_pc, "R10", "pc after store", pc_o, exp_pc);
        chk(addr == exp_pc && rw, "R10", "next fetch addr", addr, exp_pc);
        chk(ir_o == 8'hB7, "R2", "ir", 16'(ir_o), 16'h00B7);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_go = 1'b0; din = 8'h00; acc_in = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(pc_o == START, "R1", "pc", pc_o, START);
        chk(ir_o == 8'h00, "R1", "ir", 16'(ir_o), 16'h0);
        chk(addr == START && rw, "R1", "addr", addr, START);
        exp_pc = START;

        // worked example: 0x22 to 0xC200
        store(8'hC2, 8'h00, 8'h22);

        // R9: stall in the middle of a store
        acc_in = 8'h3C;
        cyc(8'hB7, exp_pc, 1'b1, 8'h00, "R2");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            bus_go = 1'b0;
            din    = 8'hFF;
            #1;
            chk(addr == exp_pc + 16'd1 && rw, "R9", "addr in stall", addr, exp_pc + 16'd1);
            chk(pc_o == exp_pc + 16'd1, "R9", "pc in stall", pc_o, exp_pc + 16'd1);
            chk(ir_o == 8'hB7, "R9", "ir in stall", 16'(ir_o), 16'h00B7);
        end
        cyc(8'h12, exp_pc + 16'd1, 1'b1, 8'h00, "R4");
        cyc(8'h34, exp_pc + 16'd2, 1'b1, 8'h00, "R4");
        cyc(8'h00, 16'h1234, 1'b0, 8'h3C, "R6");
        exp_pc = exp_pc + 16'd3;

        // R8: every other opcode is a one-cycle no-op
        for (int op = 0; op < 256; op++) begin
            if (op != 8'hB7) begin
                cyc(8'(op), exp_pc, 1'b1, 8'h00, "R8");
                exp_pc = exp_pc + 16'd1;
                @(negedge clk);
                bus_go = 1'b0;
                #1;
                chk(ir_o == 8'(op), "R2", "ir after no-op", 16'(ir_o), 16'(op));
                chk(addr == exp_pc && rw, "R8", "next fetch", addr, exp_pc);
                chk(dout == 8'h00, "R7", "dout", 16'(dout), 16'h0);
            end
        end

        // R5/R6 sweep of targets and data
        for (int k = 0; k < 64; k++) begin
            store(8'(k * 4 + 1), 8'(255 - k * 3), 8'(k ^ 8'h5A));
        end

        // R1: reset in the middle of a store
        cyc(8'hB7, exp_pc, 1'b1, 8'h00, "R2");
        cyc(8'h40, exp_pc + 16'd1, 1'b1, 8'h00, "R4");
        @(negedge clk);
        bus_go = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(pc_o == START, "R1", "pc after mid reset", pc_o, START);
        chk(ir_o == 8'h00, "R1", "ir after mid reset", 16'(ir_o), 16'h0);
        chk(addr == START && rw, "R1", "fetch after mid reset", addr, START);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule